// File: doc/BRIEF.md
# Quadrature DDS Excitation Generator

This block produces two digitally synthesized waveforms from a single phase accumulator. One is a sine stream meant for a digital-to-analog converter that drives an excitation current. The other is a cosine reference of the same frequency for an on-chip demodulator. Each clock cycle in which the block is enabled, the 32-bit accumulator advances by a programmable step, and the step sets the output frequency as step × f_clk / 2^32. A programmable offset word is added after the accumulator and before the table lookup, so the starting phase can be moved without disturbing the running phase. The 100 kHz setting used in the target system has a step of 0x0068DB8B.

The accumulator phase plus the offset selects a table address from its top 10 bits. The cosine address is that same address advanced by a quarter turn. One quarter-wave magnitude table per channel, folded by quadrant, gives signed 14-bit samples. Both samples are registered and come out together in the same cycle, each with a valid strobe. New step and offset words are written together through a load strobe.

Top module: `qdds_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, the stored step and the stored offset all clear to zero. After that edge both valid strobes are low and both samples read 0.
- R2: When `cfg_load` is high at an edge, `cfg_pinc` and `cfg_poff` are stored. An accumulator update or address capture at that same edge still uses the previously stored words. Every later edge uses the new ones, and the running accumulator value is kept.
- R3: At each edge where `en` is high, the captured phase is accumulator + offset (mod 2^32), and then the accumulator advances by the step (mod 2^32). After reset with stable words, the n-th sample (n from 0) therefore has phase n·step + offset, so the first sample has phase equal to the offset.
- R4: A phase captured at an edge where `en` is high appears as samples with both valid strobes high right after the following edge. The latency is two cycles from driving `en` to seeing the output.
- R5: The sine sample for address k = phase[31:22] is s·M[m]. Here q = k[9:8] and j = k[7:0]. m = 255−j when q is 1 or 3, and m = j otherwise. s = −1 when q is 2 or 3, and +1 otherwise. M[m] = round(8191·sin(2π(m+0.5)/1024)).
- R6: The cosine sample is the R5 value for address (k+256) mod 1024, taken from the same phase and delivered in the same cycle as the sine sample.
- R7: At an edge where `en` is low, the accumulator holds its value. One cycle later both valid strobes are low, and both samples keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the accumulator and emit a sample pair |
| cfg_load | input | 1 | Store the step and offset words |
| cfg_pinc | input | 32 | Phase step (frequency word) |
| cfg_poff | input | 32 | Phase offset word |
| sin_sample | output | 14 | Signed sine excitation sample |
| sin_valid | output | 1 | Sine sample strobe |
| cos_sample | output | 14 | Signed cosine reference sample |
| cos_valid | output | 1 | Cosine sample strobe |

## Verification
A step of exactly one table address per cycle walks all 1024 addresses. This tests every table entry and every quadrant fold on both channels, and shows whether the cosine really leads by a quarter turn. The 100 kHz step with a 90° offset, a backward step that wraps through zero, and a zero step holding a constant sample show whether the accumulation wraps modulo 2^32 and whether the offset is added after the accumulator. An enable pattern that toggles every cycle separates holding the phase from advancing it. A step and offset change in the middle of a run, plus a reset in the middle of a run, pin down the edge at which new words take effect and confirm that the first sample after reset carries the offset phase.

// File: rtl/qdds_pkg.sv
`timescale 1ns/1ps
package qdds_pkg;

    localparam int unsigned DEF_ACC_W  = 32;
    localparam int unsigned DEF_ADDR_W = 10;
    localparam int unsigned DEF_SAMP_W = 14;

    // Quadrant of the table address; the order is fixed by the two top bits.
    typedef enum logic [1:0] {
        QD_RISE     = 2'd0,
        QD_FALL     = 2'd1,
        QD_NEG_FALL = 2'd2,
        QD_NEG_RISE = 2'd3
    } quad_e;

    // Magnitude of one quarter-wave entry, sampled half a step off the axis
    // so that the mirrored quadrants need no extra entry.
    function automatic int quarter_mag(input int idx, input int qn, input int amp);
        real ang;
        ang = 6.283185307179586 * (real'(idx) + 0.5) / real'(4 * qn);
        return int'($floor(real'(amp) * $sin(ang) + 0.5));
    endfunction

    function automatic logic is_mirrored(input quad_e q);
        return (q == QD_FALL) || (q == QD_NEG_RISE);
    endfunction

    function automatic logic is_negative(input quad_e q);
        return (q == QD_NEG_FALL) || (q == QD_NEG_RISE);
    endfunction

endpackage

// File: rtl/qdds_phase.sv
`timescale 1ns/1ps
module qdds_phase #(
    parameter int unsigned ACC_W  = qdds_pkg::DEF_ACC_W,
    parameter int unsigned ADDR_W = qdds_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              cfg_load,
    input  logic [ACC_W-1:0]  cfg_pinc,
    input  logic [ACC_W-1:0]  cfg_poff,
    output logic              addr_vld,
    output logic [ADDR_W-1:0] sin_addr,
    output logic [ADDR_W-1:0] cos_addr
);

    localparam logic [ADDR_W-1:0] QUARTER = ADDR_W'(1) << (ADDR_W - 2);

    logic [ACC_W-1:0]  acc;
    logic [ACC_W-1:0]  step_r;
    logic [ACC_W-1:0]  offs_r;
    logic [ACC_W-1:0]  phase;
    logic [ADDR_W-1:0] base_addr;

    always_comb begin
        phase     = acc + offs_r;
        base_addr = phase[ACC_W-1 -: ADDR_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            step_r   <= '0;
            offs_r   <= '0;
            addr_vld <= 1'b0;
            sin_addr <= '0;
            cos_addr <= '0;
        end else begin
            if (cfg_load) begin
                step_r <= cfg_pinc;
                offs_r <= cfg_poff;
            end
            addr_vld <= en;
            if (en) begin
                acc      <= acc + step_r;
                sin_addr <= base_addr;
                cos_addr <= base_addr + QUARTER;
            end
        end
    end

    // R3: an enabled edge advances the phase by the stored step
    p_acc_step_r3: assert property (@(posedge clk) disable iff (rst)
        en |=> acc == $past(acc) + $past(step_r));

    // R7: a disabled edge leaves the phase untouched
    p_acc_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc));

    // R2: stored words change only through the load strobe
    p_cfg_stable_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> $stable(step_r) && $stable(offs_r));

endmodule

// File: rtl/qdds_wave.sv
`timescale 1ns/1ps
module qdds_wave #(
    parameter int unsigned ADDR_W = qdds_pkg::DEF_ADDR_W,
    parameter int unsigned SAMP_W = qdds_pkg::DEF_SAMP_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     addr_vld,
    input  logic [ADDR_W-1:0]        addr,
    output logic signed [SAMP_W-1:0] sample
);
    import qdds_pkg::*;

    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam int unsigned QN    = 1 << IDX_W;
    localparam int unsigned MAG_W = SAMP_W - 1;
    localparam int          AMP   = (1 << (SAMP_W - 1)) - 1;

    logic [MAG_W-1:0] rom [QN];

    for (genvar i = 0; i < QN; i++) begin : g_rom
        assign rom[i] = MAG_W'(quarter_mag(i, QN, AMP));
    end

    quad_e                    quad;
    logic [IDX_W-1:0]         idx;
    logic signed [SAMP_W-1:0] mag;
    logic signed [SAMP_W-1:0] value;

    always_comb begin
        quad  = quad_e'(addr[ADDR_W-1 -: 2]);
        idx   = is_mirrored(quad) ? ~addr[IDX_W-1:0] : addr[IDX_W-1:0];
        mag   = $signed({1'b0, rom[idx]});
        value = is_negative(quad) ? -mag : mag;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sample <= '0;
        else if (addr_vld)
            sample <= value;
    end

    // R7: without a captured address the sample holds
    p_sample_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !addr_vld |=> $stable(sample));

endmodule

// File: rtl/qdds_gen.sv
`timescale 1ns/1ps
module qdds_gen #(
    parameter int unsigned ACC_W  = qdds_pkg::DEF_ACC_W,
    parameter int unsigned ADDR_W = qdds_pkg::DEF_ADDR_W,
    parameter int unsigned SAMP_W = qdds_pkg::DEF_SAMP_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     cfg_load,
    input  logic [ACC_W-1:0]         cfg_pinc,
    input  logic [ACC_W-1:0]         cfg_poff,
    output logic signed [SAMP_W-1:0] sin_sample,
    output logic                     sin_valid,
    output logic signed [SAMP_W-1:0] cos_sample,
    output logic                     cos_valid
);

    localparam int AMP  = (1 << (SAMP_W - 1)) - 1;
    localparam int R_LO = (AMP - 1) * (AMP - 1);
    localparam int R_HI = (AMP + 1) * (AMP + 1);

    logic              addr_vld;
    logic [ADDR_W-1:0] ch_addr [2];
    logic signed [SAMP_W-1:0] ch_smp [2];
    logic              out_vld;

    qdds_phase #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .cfg_load (cfg_load),
        .cfg_pinc (cfg_pinc),
        .cfg_poff (cfg_poff),
        .addr_vld (addr_vld),
        .sin_addr (ch_addr[0]),
        .cos_addr (ch_addr[1])
    );

    for (genvar c = 0; c < 2; c++) begin : g_chan
        qdds_wave #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_wave (
            .clk      (clk),
            .rst      (rst),
            .addr_vld (addr_vld),
            .addr     (ch_addr[c]),
            .sample   (ch_smp[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_vld <= 1'b0;
        else
            out_vld <= addr_vld;
    end

    assign sin_sample = ch_smp[0];
    assign cos_sample = ch_smp[1];
    assign sin_valid  = out_vld;
    assign cos_valid  = out_vld;

    int radius_sq;
    always_comb radius_sq = int'(sin_sample) * int'(sin_sample)
                          + int'(cos_sample) * int'(cos_sample);

    // R4: an enabled edge yields a strobed pair two cycles later
    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        en |-> ##2 sin_valid);

    // R7: a disabled edge yields no strobe two cycles later
    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !en |-> ##2 !sin_valid);

    // R6: a strobed pair lies on the unit circle within rounding
    p_unit_circle_r6: assert property (@(posedge clk) disable iff (rst)
        sin_valid |-> (radius_sq >= R_LO) && (radius_sq <= R_HI));

endmodule

// File: tb/qdds_gen_bench.sv
`timescale 1ns/1ps
module qdds_gen_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic        cfg_load;
    logic [31:0] cfg_pinc;
    logic [31:0] cfg_poff;
    logic signed [13:0] sin_sample;
    logic signed [13:0] cos_sample;
    logic        sin_valid;
    logic        cos_valid;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    qdds_gen u_qdds_gen (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .cfg_load   (cfg_load),
        .cfg_pinc   (cfg_pinc),
        .cfg_poff   (cfg_poff),
        .sin_sample (sin_sample),
        .sin_valid  (sin_valid),
        .cos_sample (cos_sample),
        .cos_valid  (cos_valid)
    );

    // Reference model state, built from the requirements
    logic [31:0] m_acc, m_step, m_offs;
    logic        m_v1, m_v2;
    logic [9:0]  m_addr;
    int          e_sin, e_cos;

    function automatic int wave_ref(input logic [9:0] k);
        int  m;
        int  mag;
        real v;
        m   = k[8] ? (255 - int'(k[7:0])) : int'(k[7:0]);
        v   = 8191.0 * $sin(6.283185307179586 * (real'(m) + 0.5) / 1024.0);
        mag = int'($floor(v + 0.5));
        return k[9] ? -mag : mag;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic r, input logic e, input logic ld,
                        input logic [31:0] pi, input logic [31:0] po,
                        input string req);
        rst = r; en = e; cfg_load = ld; cfg_pinc = pi; cfg_poff = po;
        @(posedge clk);
        if (r) begin
            m_acc = '0; m_step = '0; m_offs = '0;
            m_v1 = 1'b0; m_v2 = 1'b0; m_addr = '0; e_sin = 0; e_cos = 0;
        end else begin
            m_v2 = m_v1;
            if (m_v1) begin
                e_sin = wave_ref(m_addr);
                e_cos = wave_ref(m_addr + 10'd256);
            end
            m_v1 = e;
            if (e) begin
                m_addr = 10'((m_acc + m_offs) >> 22);
                m_acc  = m_acc + m_step;
            end
            if (ld) begin
                m_step = pi;
                m_offs = po;
            end
        end
        @(negedge clk);
        chk({req, " sin_valid"}, int'(sin_valid), int'(m_v2));
        chk({req, " cos_valid"}, int'(cos_valid), int'(m_v2));
        chk({req, " sin_sample"}, int'(sin_sample), e_sin);
        chk({req, " cos_sample"}, int'(cos_sample), e_cos);
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b1, 1'b0, '0, '0, req);
    endtask

    initial begin
        rst = 1'b1; en = 1'b0; cfg_load = 1'b0; cfg_pinc = '0; cfg_poff = '0;
        @(negedge clk);
        // R1: reset state
        tick(1'b1, 1'b0, 1'b0, '0, '0, "R1 reset");
        tick(1'b1, 1'b1, 1'b1, 32'h1234_5678, 32'h9abc_def0, "R1 reset");

        // R5 R6: one address per cycle walks the whole table on both channels
        tick(1'b0, 1'b0, 1'b1, 32'h0040_0000, 32'h0000_0000, "R2 load idle");
        run(1026, "R5 R6 full sweep");

        // R3: first sample after reset carries the offset, 100 kHz step, 90 deg offset
        tick(1'b1, 1'b0, 1'b0, '0, '0, "R1 reset");
        tick(1'b0, 1'b0, 1'b1, 32'h0068_DB8B, 32'h4000_0000, "R2 load idle");
        run(600, "R3 nominal step");

        // R3: backward step wrapping through zero with an odd offset
        tick(1'b0, 1'b0, 1'b1, 32'hFFC0_0000, 32'h1234_5678, "R2 load idle");
        run(300, "R3 wrap");

        // R7: enable toggling every cycle holds phase and samples
        tick(1'b0, 1'b0, 1'b1, 32'h0100_0000, 32'h0000_0000, "R2 load idle");
        for (int i = 0; i < 120; i++)
            tick(1'b0, i[0], 1'b0, '0, '0, "R7 toggle");
        for (int i = 0; i < 4; i++)
            tick(1'b0, 1'b0, 1'b0, '0, '0, "R7 idle hold");

        // R2: words changed mid-run, old words used at the load edge
        run(5, "R4 restart");
        tick(1'b0, 1'b1, 1'b1, 32'h0731_0001, 32'hC000_0000, "R2 live load");
        run(40, "R2 after load");
        tick(1'b0, 1'b1, 1'b1, 32'h0000_0000, 32'h2000_0000, "R2 zero step");
        run(20, "R3 constant phase");

        // R4: single enable pulse gives a single strobe after two cycles
        tick(1'b0, 1'b1, 1'b1, 32'h0555_5555, 32'h0000_0000, "R4 pulse");
        for (int i = 0; i < 4; i++)
            tick(1'b0, 1'b0, 1'b0, '0, '0, "R4 pulse tail");

        // R1 R3: reset mid-run restarts from the offset phase
        run(7, "R3 pre reset");
        tick(1'b1, 1'b1, 1'b0, '0, '0, "R1 mid reset");
        tick(1'b0, 1'b1, 1'b1, 32'h0003_0000, 32'h8000_0000, "R2 load running");
        run(50, "R3 after reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule